// File: doc/BRIEF.md
# Clock Synthesizer Retune Write Sequencer

This block walks a clock synthesizer through a complete retune over a 16-bit register access port. A controller presents three settings and pulses `start`:

- an output divide, in eighths;
- a feedback multiply, in eighths;
- an integer input divide.

The controller also presents a lock-detector word and a loop-filter word taken from an external lookup. The sequencer captures all of these and derives the high-time, low-time, edge, no-count and fractional fields of each divider. It then issues thirteen masked register updates in a fixed order.

Each masked update whose mask is not all ones becomes a read-modify-write. The register is read first. Then the bits under the mask are replaced and every other bit keeps the value just read. The sequencer holds each access on the port until the port signals ready. It pulses `done` once the last write is accepted. A start request that carries a zero in any of the three settings is refused with a one-cycle `reject` pulse, and no access is made.

The controller is a single enumerated state machine with six states:

- `S_IDLE`: waiting. On `start` with a zero setting it goes to `S_REJ`. On `start` with valid settings it goes to `S_PICK`.
- `S_REJ`: the `reject` pulse. It always returns to `S_IDLE`.
- `S_PICK`: chooses the access for the current step. It goes to `S_RD` when the mask is partial and to `S_WR` when the mask is all ones.
- `S_RD`: holds a read. Once the read is accepted it goes to `S_WR`.
- `S_WR`: holds a write. Once the write is accepted it goes back to `S_PICK`, or to `S_DONE` after the final step.
- `S_DONE`: the `done` pulse. It always returns to `S_IDLE`.

Top module: `reconfig_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `port_req`, `busy`, `done` and `reject` are all 0.
- R2: A `start` seen while idle with `out_div`, `fb_mul` or `in_div` equal to zero raises `reject` for exactly one cycle. The block makes no port access and `busy` stays 0.
- R3: An accepted start writes these addresses, in this order, exactly once each: 0x28, 0x08, 0x09, 0x07, 0x16, 0x14, 0x15, 0x13, 0x18, 0x19, 0x1A, 0x4E, 0x4F.
- R4: Each write is preceded by an accepted read of the same address. The written word equals (read data AND NOT mask) OR (value AND mask).
- R5: The first write (0x28) uses mask 0x9800. Its value is 0x9800 when `out_div[2:0]` or `fb_mul[2:0]` is nonzero, and 0 otherwise.
- R6: For the output divider (0x08, 0x09, 0x07) and the feedback divider (0x14, 0x15, 0x13), with integer part D = setting>>3 and fraction F = setting[2:0], the three words are packed as follows:
  - First word: high in bits 11:6 and low in bits 5:0, under mask 0xEFFF.
  - Second word: F in bits 14:12, fraction enable in bit 11, rising flag in bit 10, edge in bit 7 and no-count in bit 6, under mask 0x7FFF.
  - Third word: phase in bits 13:11 and falling flag in bit 10, under mask 0x3C00.
- R7: The divider fields are derived as follows. All other fields are 0 unless a rule below sets them.
  - If D = 1: no-count = 1.
  - Else if F = 0: high = D/2, edge = D mod 2, low = D − high.
  - Else, fraction enable = 1:
    - high = low = D/2 and edge = D mod 2.
    - An even D decrements high and sets the rising flag.
    - An even D or F = 1 decrements low.
    - The falling flag = (even D XOR F = 1) OR (D = 2 AND F = 1).
    - phase = 4·edge + F/2.
- R8: The input-divider word (0x16) uses the R7 rules with F = 0. It packs edge in bit 13, no-count in bit 12, high in bits 11:6 and low in bits 5:0, under mask 0x3FFF.
- R9: The lock words are as follows:
  - 0x18 takes `lock_cnt` under mask 0x03FF.
  - 0x19 takes (`lock_dly_a` << 10) | 1 under mask 0x7FFF.
  - 0x1A takes (`lock_dly_b` << 10) | 0x3E9 under mask 0x7FFF.
- R10: The filter words are as follows:
  - 0x4E takes `filter_word[31:16]` under mask 0x9900.
  - 0x4F takes `filter_word[15:0]` under mask 0x9900.
- R11: A request with `port_ready` low is held on the next cycle with the same address, direction and write data.
- R12: `done` is high for exactly one cycle, after the thirteenth write is accepted. A `start` seen while busy is ignored and leaves the sequence in progress unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a retune with the presented settings |
| out_div | input | OUT_W | Output divide in eighths |
| fb_mul | input | FB_W | Feedback multiply in eighths |
| in_div | input | IN_W | Integer input divide |
| lock_cnt | input | 10 | Lock-detector count field |
| lock_dly_a | input | 5 | First lock-detector delay field |
| lock_dly_b | input | 5 | Second lock-detector delay field |
| filter_word | input | 32 | Loop-filter word, upper half then lower half |
| port_req | output | 1 | Access request on the register port |
| port_write | output | 1 | 1 for write, 0 for read |
| port_addr | output | 7 | Register address |
| port_wdata | output | 16 | Write data |
| port_ready | input | 1 | Port accepts the current request this cycle |
| port_rdata | input | 16 | Read data, valid while a read is accepted |
| busy | output | 1 | A retune is in progress |
| done | output | 1 | One-cycle pulse at the end of a retune |
| reject | output | 1 | One-cycle pulse for a refused start |

## Verification
The bench builds the block with its default widths: OUT_W=11, FB_W=10 and IN_W=7. These widths put integer divides from 1 upward, every fraction from 1 to 7 eighths, and input divides both odd and even within reach. That range covers the no-count case (D=1), the divide-2-with-fraction-1 falling-flag exception, and the even and odd fractional branches. It also covers power words both off and on.

The bench uses two port-ready patterns, one of them sparse. Requests are therefore held across long stalls, and every read-modify-write merges against register contents that differ at each address.

// File: rtl/reconfig_seq_pkg.sv
package reconfig_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REJ,
        S_PICK,
        S_RD,
        S_WR,
        S_DONE
    } seq_state_e;

    localparam int NUM_STEPS = 13;
    localparam int STEP_W    = $clog2(NUM_STEPS);
    localparam int PADDR_W   = 7;
    localparam int PDATA_W   = 16;

    typedef struct packed {
        logic [5:0] hi;
        logic [5:0] lo;
        logic       edg;
        logic       nocnt;
        logic       fen;
        logic [2:0] frac;
        logic       wf_r;
        logic       wf_f;
        logic [2:0] phase;
    } div_fields_t;

endpackage

// File: rtl/div_fields.sv
module div_fields
    import reconfig_seq_pkg::*;
#(
    parameter int INT_W = 8
) (
    input  logic [INT_W-1:0] int_part,
    input  logic [2:0]       frac_part,
    output div_fields_t      f
);

    logic       even;
    logic       frac_one;
    logic [5:0] half;

    always_comb begin
        even     = ~int_part[0];
        frac_one = (frac_part == 3'd1);
        half     = 6'(int_part >> 1);
        f        = '0;
        if (int_part == INT_W'(1)) begin
            f.nocnt = 1'b1;
        end else if (frac_part == 3'd0) begin
            f.hi  = half;
            f.edg = int_part[0];
            f.lo  = 6'(int_part) - half;
        end else begin
            f.fen  = 1'b1;
            f.frac = frac_part;
            f.edg  = int_part[0];
            f.hi   = even ? half - 6'd1 : half;
            f.wf_r = even;
            f.lo   = (even || frac_one) ? half - 6'd1 : half;
            f.wf_f = (even ^ frac_one) || ((int_part == INT_W'(2)) && frac_one);
            f.phase = {int_part[0], 2'b00} + {1'b0, frac_part[2:1]};
        end
    end

endmodule

// File: rtl/step_table.sv
module step_table
    import reconfig_seq_pkg::*;
(
    input  logic [STEP_W-1:0]  step,
    input  div_fields_t        out_f,
    input  div_fields_t        fb_f,
    input  div_fields_t        in_f,
    input  logic               power_on,
    input  logic [9:0]         lock_cnt,
    input  logic [4:0]         lock_dly_a,
    input  logic [4:0]         lock_dly_b,
    input  logic [31:0]        filter_word,
    output logic [PADDR_W-1:0] addr,
    output logic [PDATA_W-1:0] value,
    output logic [PDATA_W-1:0] mask
);

    function automatic logic [15:0] word_a(input div_fields_t d);
        return {4'b0000, d.hi, d.lo};
    endfunction

    function automatic logic [15:0] word_b(input div_fields_t d);
        return {1'b0, d.frac, d.fen, d.wf_r, 2'b00, d.edg, d.nocnt, 6'b0};
    endfunction

    function automatic logic [15:0] word_c(input div_fields_t d);
        return {2'b00, d.phase, d.wf_f, 10'b0};
    endfunction

    always_comb begin
        addr  = '0;
        value = '0;
        mask  = 16'hFFFF;
        unique case (step)
            4'd0:  begin addr = 7'h28; value = power_on ? 16'h9800 : 16'h0000; mask = 16'h9800; end
            4'd1:  begin addr = 7'h08; value = word_a(out_f); mask = 16'hEFFF; end
            4'd2:  begin addr = 7'h09; value = word_b(out_f); mask = 16'h7FFF; end
            4'd3:  begin addr = 7'h07; value = word_c(out_f); mask = 16'h3C00; end
            4'd4:  begin
                addr  = 7'h16;
                value = {2'b00, in_f.edg, in_f.nocnt, in_f.hi, in_f.lo};
                mask  = 16'h3FFF;
            end
            4'd5:  begin addr = 7'h14; value = word_a(fb_f); mask = 16'hEFFF; end
            4'd6:  begin addr = 7'h15; value = word_b(fb_f); mask = 16'h7FFF; end
            4'd7:  begin addr = 7'h13; value = word_c(fb_f); mask = 16'h3C00; end
            4'd8:  begin addr = 7'h18; value = {6'b0, lock_cnt}; mask = 16'h03FF; end
            4'd9:  begin addr = 7'h19; value = {1'b0, lock_dly_a, 10'h001}; mask = 16'h7FFF; end
            4'd10: begin addr = 7'h1A; value = {1'b0, lock_dly_b, 10'h3E9}; mask = 16'h7FFF; end
            4'd11: begin addr = 7'h4E; value = filter_word[31:16]; mask = 16'h9900; end
            4'd12: begin addr = 7'h4F; value = filter_word[15:0]; mask = 16'h9900; end
            default: begin addr = '0; value = '0; mask = 16'hFFFF; end
        endcase
    end

endmodule

// File: rtl/reconfig_seq.sv
module reconfig_seq
    import reconfig_seq_pkg::*;
#(
    parameter int OUT_W = 11,
    parameter int FB_W  = 10,
    parameter int IN_W  = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [OUT_W-1:0]   out_div,
    input  logic [FB_W-1:0]    fb_mul,
    input  logic [IN_W-1:0]    in_div,
    input  logic [9:0]         lock_cnt,
    input  logic [4:0]         lock_dly_a,
    input  logic [4:0]         lock_dly_b,
    input  logic [31:0]        filter_word,
    output logic               port_req,
    output logic               port_write,
    output logic [PADDR_W-1:0] port_addr,
    output logic [PDATA_W-1:0] port_wdata,
    input  logic               port_ready,
    input  logic [PDATA_W-1:0] port_rdata,
    output logic               busy,
    output logic               done,
    output logic               reject
);

    localparam int OUT_INT_W = OUT_W - 3;
    localparam int FB_INT_W  = FB_W - 3;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    seq_state_e state_q, state_d;

    logic [OUT_W-1:0]   out_q;
    logic [FB_W-1:0]    fb_q;
    logic [IN_W-1:0]    in_q;
    logic [9:0]         lcnt_q;
    logic [4:0]         ldly_a_q;
    logic [4:0]         ldly_b_q;
    logic [31:0]        filt_q;
    logic [STEP_W-1:0]  step_q;
    logic [PDATA_W-1:0] rd_q;

    div_fields_t out_f, fb_f, in_f;
    logic [PADDR_W-1:0] step_addr;
    logic [PDATA_W-1:0] step_value;
    logic [PDATA_W-1:0] step_mask;
    logic               bad_req;
    logic               last_step;

    assign bad_req   = (out_div == '0) || (fb_mul == '0) || (in_div == '0);
    assign last_step = (step_q == LAST_STEP);

    div_fields #(.INT_W(OUT_INT_W)) u_out_fields (
        .int_part (out_q[OUT_W-1:3]),
        .frac_part(out_q[2:0]),
        .f        (out_f)
    );

    div_fields #(.INT_W(FB_INT_W)) u_fb_fields (
        .int_part (fb_q[FB_W-1:3]),
        .frac_part(fb_q[2:0]),
        .f        (fb_f)
    );

    div_fields #(.INT_W(IN_W)) u_in_fields (
        .int_part (in_q),
        .frac_part(3'd0),
        .f        (in_f)
    );

    step_table u_table (
        .step       (step_q),
        .out_f      (out_f),
        .fb_f       (fb_f),
        .in_f       (in_f),
        .power_on   ((out_q[2:0] != 3'd0) || (fb_q[2:0] != 3'd0)),
        .lock_cnt   (lcnt_q),
        .lock_dly_a (ldly_a_q),
        .lock_dly_b (ldly_b_q),
        .filter_word(filt_q),
        .addr       (step_addr),
        .value      (step_value),
        .mask       (step_mask)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = bad_req ? S_REJ : S_PICK;
            S_REJ:  state_d = S_IDLE;
            S_PICK: state_d = (step_mask == 16'hFFFF) ? S_WR : S_RD;
            S_RD:   if (port_ready) state_d = S_WR;
            S_WR:   if (port_ready) state_d = last_step ? S_DONE : S_PICK;
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Captured settings, step index and read shadow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q    <= '0;
            fb_q     <= '0;
            in_q     <= '0;
            lcnt_q   <= '0;
            ldly_a_q <= '0;
            ldly_b_q <= '0;
            filt_q   <= '0;
            step_q   <= '0;
            rd_q     <= '0;
        end else begin
            if (state_q == S_IDLE && start && !bad_req) begin
                out_q    <= out_div;
                fb_q     <= fb_mul;
                in_q     <= in_div;
                lcnt_q   <= lock_cnt;
                ldly_a_q <= lock_dly_a;
                ldly_b_q <= lock_dly_b;
                filt_q   <= filter_word;
                step_q   <= '0;
                rd_q     <= '0;
            end
            if (state_q == S_PICK && step_mask == 16'hFFFF) rd_q <= '0;
            if (state_q == S_RD && port_ready) rd_q <= port_rdata;
            if (state_q == S_WR && port_ready && !last_step) step_q <= step_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        port_req   = (state_q == S_RD) || (state_q == S_WR);
        port_write = (state_q == S_WR);
        port_addr  = step_addr;
        port_wdata = (rd_q & ~step_mask) | (step_value & step_mask);
        busy       = (state_q == S_PICK) || (state_q == S_RD) ||
                     (state_q == S_WR)   || (state_q == S_DONE);
        done       = (state_q == S_DONE);
        reject     = (state_q == S_REJ);
    end

endmodule

// File: rtl/reconfig_seq_chk.sv
module reconfig_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        port_req,
    input logic        port_write,
    input logic [6:0]  port_addr,
    input logic [15:0] port_wdata,
    input logic        port_ready,
    input logic [15:0] port_rdata,
    input logic [15:0] step_mask,
    input logic        busy,
    input logic        done,
    input logic        reject
);

    logic [15:0] seen_rd;

    always_ff @(posedge clk) begin
        if (!rst_n) seen_rd <= '0;
        else if (port_req && !port_write && port_ready) seen_rd <= port_rdata;
    end

    // R11: a stalled request is held unchanged
    a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (port_req && !port_ready) |=> (port_req && $stable(port_addr) &&
                                       $stable(port_write) && $stable(port_wdata)));

    // R4: bits outside the mask carry the value read from the port
    a_r4_merge_keeps_read: assert property (@(posedge clk) disable iff (!rst_n)
        (port_req && port_write && step_mask != 16'hFFFF) |->
            (((port_wdata ^ seen_rd) & ~step_mask) == 16'h0000));

    // R3: a retune opens at the power register
    a_r3_first_is_power: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (port_addr == 7'h28));

    // R12: done is a single-cycle pulse with no access alongside
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r12_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !port_req);

    // R2: a rejection is a single pulse and leaves the block idle
    a_r2_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> (!reject && !busy && !port_req));

endmodule

bind reconfig_seq reconfig_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_req  (port_req),
    .port_write(port_write),
    .port_addr (port_addr),
    .port_wdata(port_wdata),
    .port_ready(port_ready),
    .port_rdata(port_rdata),
    .step_mask (step_mask),
    .busy      (busy),
    .done      (done),
    .reject    (reject)
);

// File: tb/reconfig_seq_tb.sv
module reconfig_seq_tb;

    localparam int OUT_W = 11;
    localparam int FB_W  = 10;
    localparam int IN_W  = 7;

    typedef struct packed {
        logic [5:0] hi;
        logic [5:0] lo;
        logic       e;
        logic       nc;
        logic       fen;
        logic [2:0] fr;
        logic       wr;
        logic       wf;
        logic [2:0] ph;
    } exp_f_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [OUT_W-1:0] out_div = '0;
    logic [FB_W-1:0]  fb_mul = '0;
    logic [IN_W-1:0]  in_div = '0;
    logic [9:0]       lock_cnt = '0;
    logic [4:0]       lock_dly_a = '0;
    logic [4:0]       lock_dly_b = '0;
    logic [31:0]      filter_word = '0;
    logic             port_req, port_write;
    logic [6:0]       port_addr;
    logic [15:0]      port_wdata;
    logic             port_ready = 1'b0;
    logic [15:0]      port_rdata;
    logic             busy, done, reject;

    logic [15:0] mem [0:127];
    assign port_rdata = mem[port_addr];

    always #10 clk = ~clk;

    reconfig_seq #(.OUT_W(OUT_W), .FB_W(FB_W), .IN_W(IN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .out_div(out_div), .fb_mul(fb_mul), .in_div(in_div),
        .lock_cnt(lock_cnt), .lock_dly_a(lock_dly_a), .lock_dly_b(lock_dly_b),
        .filter_word(filter_word),
        .port_req(port_req), .port_write(port_write), .port_addr(port_addr),
        .port_wdata(port_wdata), .port_ready(port_ready), .port_rdata(port_rdata),
        .busy(busy), .done(done), .reject(reject)
    );

    int n_chk = 0;
    int n_bad = 0;
    int n_rd = 0;
    int n_wr = 0;
    int n_done = 0;
    int n_rej = 0;
    int cyc = 0;
    bit slow = 1'b0;

    logic [6:0]  q_addr [$];
    logic [15:0] q_data [$];
    int          q_step [$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string step_tag(input int s);
        if (s == 0) return "R5 power";
        if (s == 4) return "R8 input divider";
        if (s >= 8 && s <= 10) return "R9 lock";
        if (s >= 11) return "R10 filter";
        return "R6 R7 divider";
    endfunction

    function automatic exp_f_t mk(input int d, input int f);
        exp_f_t r;
        int hi, lo, e;
        r = '0;
        if (d == 1) begin
            r.nc = 1'b1;
        end else begin
            e = d % 2;
            hi = d / 2;
            r.e = e[0];
            if (f == 0) begin
                lo = d - hi;
            end else begin
                lo = d / 2;
                r.fen = 1'b1;
                r.fr = 3'(f);
                if (e == 0) begin
                    hi = hi - 1;
                    r.wr = 1'b1;
                end
                if (e == 0 || f == 1) lo = lo - 1;
                r.wf = ((e == 0) != (f == 1)) || (d == 2 && f == 1);
                r.ph = 3'(e * 4 + f / 2);
            end
            r.hi = 6'(hi);
            r.lo = 6'(lo);
        end
        return r;
    endfunction

    // Monitor: drives ready, serves the port, compares against the scoreboard
    logic        pend_prev = 1'b0;
    logic [6:0]  pa_prev;
    logic        pw_prev;
    logic [15:0] pd_prev;
    logic        done_prev = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (pend_prev)
            chk(port_req && port_addr == pa_prev && port_write == pw_prev && port_wdata == pd_prev,
                "R11 stalled request held", {port_req, port_write, 7'b0, port_addr, port_wdata[14:0]},
                {1'b1, pw_prev, 7'b0, pa_prev, pd_prev[14:0]});
        port_ready = slow ? (cyc % 5 == 4) : (cyc % 3 != 0);
        pend_prev = port_req && !port_ready;
        pa_prev = port_addr;
        pw_prev = port_write;
        pd_prev = port_wdata;
        if (port_req && port_ready) begin
            if (!port_write) begin
                n_rd++;
                if (q_addr.size() == 0) chk(1'b0, "R4 read with nothing expected", {25'b0, port_addr}, 32'h0);
                else chk(port_addr == q_addr[0], "R4 read address before write", {25'b0, port_addr}, {25'b0, q_addr[0]});
            end else begin
                n_wr++;
                if (q_addr.size() == 0) begin
                    chk(1'b0, "R3 unexpected write", {25'b0, port_addr}, 32'h0);
                end else begin
                    chk(port_addr == q_addr[0], "R3 write order", {25'b0, port_addr}, {25'b0, q_addr[0]});
                    chk(port_wdata == q_data[0], step_tag(q_step[0]), {16'b0, port_wdata}, {16'b0, q_data[0]});
                    void'(q_addr.pop_front());
                    void'(q_data.pop_front());
                    void'(q_step.pop_front());
                end
                mem[port_addr] = port_wdata;
            end
        end
        if (done) begin
            n_done++;
            chk(q_addr.size() == 0, "R12 done after last write", q_addr.size(), 0);
        end
        if (done && done_prev) chk(1'b0, "R12 done wider than one cycle", 1, 0);
        done_prev = done;
        if (reject) n_rej++;
    end

    // Driver: computes expectations, pushes them, starts the retune
    task automatic retune(input int od, input int fm, input int idv, input logic [9:0] lc,
                          input logic [4:0] la, input logic [4:0] lb, input logic [31:0] fl,
                          input bit poke);
        logic [6:0]  ad [13];
        logic [15:0] vl [13];
        logic [15:0] mk_ [13];
        exp_f_t fo, fb, fi;
        int d0, r0, w0, w;
        fo = mk(od / 8, od % 8);
        fb = mk(fm / 8, fm % 8);
        fi = mk(idv, 0);
        ad[0] = 7'h28; vl[0] = ((od % 8) != 0 || (fm % 8) != 0) ? 16'h9800 : 16'h0; mk_[0] = 16'h9800;
        ad[1] = 7'h08; vl[1] = {4'b0, fo.hi, fo.lo}; mk_[1] = 16'hEFFF;
        ad[2] = 7'h09; vl[2] = (16'(fo.fr) << 12) | (16'(fo.fen) << 11) | (16'(fo.wr) << 10) |
                               (16'(fo.e) << 7) | (16'(fo.nc) << 6); mk_[2] = 16'h7FFF;
        ad[3] = 7'h07; vl[3] = (16'(fo.ph) << 11) | (16'(fo.wf) << 10); mk_[3] = 16'h3C00;
        ad[4] = 7'h16; vl[4] = (16'(fi.e) << 13) | (16'(fi.nc) << 12) | (16'(fi.hi) << 6) | 16'(fi.lo);
        mk_[4] = 16'h3FFF;
        ad[5] = 7'h14; vl[5] = {4'b0, fb.hi, fb.lo}; mk_[5] = 16'hEFFF;
        ad[6] = 7'h15; vl[6] = (16'(fb.fr) << 12) | (16'(fb.fen) << 11) | (16'(fb.wr) << 10) |
                               (16'(fb.e) << 7) | (16'(fb.nc) << 6); mk_[6] = 16'h7FFF;
        ad[7] = 7'h13; vl[7] = (16'(fb.ph) << 11) | (16'(fb.wf) << 10); mk_[7] = 16'h3C00;
        ad[8] = 7'h18; vl[8] = 16'(lc); mk_[8] = 16'h03FF;
        ad[9] = 7'h19; vl[9] = (16'(la) << 10) | 16'h0001; mk_[9] = 16'h7FFF;
        ad[10] = 7'h1A; vl[10] = (16'(lb) << 10) | 16'h03E9; mk_[10] = 16'h7FFF;
        ad[11] = 7'h4E; vl[11] = fl[31:16]; mk_[11] = 16'h9900;
        ad[12] = 7'h4F; vl[12] = fl[15:0]; mk_[12] = 16'h9900;
        for (int i = 0; i < 13; i++) begin
            q_addr.push_back(ad[i]);
            q_data.push_back((mem[ad[i]] & ~mk_[i]) | (vl[i] & mk_[i]));
            q_step.push_back(i);
        end
        d0 = n_done; r0 = n_rd; w0 = n_wr;
        @(negedge clk);
        out_div = OUT_W'(od); fb_mul = FB_W'(fm); in_div = IN_W'(idv);
        lock_cnt = lc; lock_dly_a = la; lock_dly_b = lb; filter_word = fl;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (8) @(negedge clk);
            out_div = 11'd77; fb_mul = 10'd99; in_div = 7'd9; filter_word = 32'hFFFF_FFFF;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1 && reject == 1'b0, "R12 start while busy ignored", {busy, reject}, 2'b10);
        end
        w = 0;
        while (n_done == d0 && w < 4000) begin
            @(negedge clk);
            w++;
        end
        chk(n_done == d0 + 1, "R12 done seen once", n_done - d0, 1);
        chk(q_addr.size() == 0, "R3 all writes issued", q_addr.size(), 0);
        chk(n_wr - w0 == 13, "R3 write count", n_wr - w0, 13);
        chk(n_rd - r0 == 13, "R4 read count", n_rd - r0, 13);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R12 idle after done", {busy, done}, 2'b00);
    endtask

    task automatic try_reject(input int od, input int fm, input int idv);
        int r0, w0, j0;
        r0 = n_rd; w0 = n_wr; j0 = n_rej;
        @(negedge clk);
        out_div = OUT_W'(od); fb_mul = FB_W'(fm); in_div = IN_W'(idv);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(reject == 1'b1 && busy == 1'b0, "R2 reject pulse", {reject, busy}, 2'b10);
        repeat (4) @(negedge clk);
        chk(reject == 1'b0 && busy == 1'b0 && port_req == 1'b0, "R2 idle after reject",
            {reject, busy, port_req}, 3'b000);
        chk(n_rej - j0 == 1, "R2 reject one cycle", n_rej - j0, 1);
        chk(n_rd == r0 && n_wr == w0, "R2 no port access", n_rd + n_wr, r0 + w0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 16'(i * 16'h1357) ^ 16'hC3A5;
        repeat (3) @(negedge clk);
        chk(port_req == 0 && busy == 0 && done == 0 && reject == 0, "R1 in reset",
            {port_req, busy, done, reject}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(port_req == 0 && busy == 0 && done == 0 && reject == 0, "R1 after reset",
            {port_req, busy, done, reject}, 4'b0000);

        // R5 power off, integer divides
        retune(40, 80, 1, 10'h190, 5'h1F, 5'h1F, 32'h0100_9090, 1'b0);
        // R7 odd/even fractional branches, sparse ready for R11
        slow = 1'b1;
        retune(35, 73, 3, 10'h3E8, 5'h06, 5'h06, 32'h0800_1090, 1'b0);
        slow = 1'b0;
        // R7 divide 2 with fraction 1, even input divide (R8)
        retune(17, 64, 4, 10'h12C, 5'h1F, 5'h1F, 32'h0100_8090, 1'b0);
        // R7 no-count at divide 1, even fractional feedback
        retune(8, 50, 2, 10'h271, 5'h0B, 5'h0E, 32'hA5A5_5A5A, 1'b0);
        // R12 start while busy
        retune(24, 97, 5, 10'h2BC, 5'h13, 5'h19, 32'h0800_9090, 1'b1);

        try_reject(0, 80, 1);
        try_reject(40, 0, 1);
        try_reject(40, 80, 0);

        // R6 R7 odd integer part with fraction after rejections
        retune(61, 15, 7, 10'h0FA, 5'h1C, 5'h11, 32'h0100_1990, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule